// File: doc/BRIEF.md
# Power-of-Two Clock Divider Bank

This block holds several identical clock dividers, all run from one crystal reference clock. Each divider has two small registers. One holds a 3-bit rate code and the other holds an on/off bit. When a divider is running, its output is the reference clock divided by a power of two that the code selects. Register writes and reads come in on a flat address bus. The bus that carries them is outside this block.

Turning a divider on or off does not change its output at once. The change is made at a point where the output is low, so no shortened pulse reaches the output. A per-divider busy flag stays high for a fixed settle interval, and that interval grows with the divide ratio in use. Software rewrites the rate code only while the divider is off. A code written while it runs is stored and takes effect at the next turn-on.

Top module: `divClkBank`

## Requirements
- R1: After synchronous reset, every register reads zero, every divided output is low and every busy flag is low.
- R2: Divider i sits at base address i×0x100. Its rate code is held in bits [2:0] at offset 0x43 and its on/off bit is bit 7 at offset 0x46. Reads return those fields with all other bits zero. Other offsets read zero, and writes to them change nothing.
- R3: A write to one divider leaves the registers of every other divider unchanged.
- R4: Rate code c selects ratio 2^(c−1), and code 0 acts like code 1. For ratios of 2 or more, the output has period equal to the ratio, with exactly ratio/2 reference cycles high and ratio/2 low.
- R5: At ratio 1, a running output follows the reference clock: high during its high phase and low during its low phase.
- R6: Setting the on bit raises busy on the first reference edge after the write edge. Busy then stays high for exactly 2 + 3×ratio cycles, where the ratio comes from the stored code.
- R7: Clearing the on bit raises busy on the next edge for exactly 3×ratio cycles, using the ratio the divider is running at. The output is low once busy falls and stays low.
- R8: A started output begins low. For ratio r ≥ 2, its first rising edge is r/2 reference edges after the edge where busy rises. For ratio 1, the first high phase begins one edge after busy rises.
- R9: A rate code written while the divider runs reads back at once. It does not change the running ratio or the turn-off settle length, and it applies at the next turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address: divider index above bit 8, offset in bits [7:0] |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| divClkOut | output | NUM_DIV | Divided clock per divider |
| divBusy | output | NUM_DIV | Settle-in-progress flag per divider |

## Verification
Call the write edge T. Busy is first due high after edge T+1 and falls after T+1+S, where S is the settle length. A divided output with ratio r ≥ 2 first rises at edge T+1+r/2. A ratio-1 output first shows a high phase at edge T+2. The bench samples 2 ns after each rising edge and counts edges from the write edge, so each of these due points is checked by its own sample index. Ratio-1 low phases are sampled 7 ns after the edge. The bench sweeps every code on both dividers and compares busy lengths and high/low run lengths with values it computes itself from the code.

// File: rtl/divbank_pkg.sv
package divbank_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic start;
    logic stop;
  } gateStb_t;

  // Divide ratio selected by a 3-bit code; code 0 behaves as code 1
  function automatic int unsigned ratioOf(input logic [2:0] code);
    if (code == 3'd0) return 32'd1;
    return 32'd1 << (int'(code) - 1);
  endfunction

  localparam int unsigned MAX_RATIO = 64;

endpackage

// File: rtl/divRegFile.sv
module divRegFile #(
  parameter int NUM_DIV = 2,
  parameter int ADDR_W  = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                wrData,
  output logic [7:0]                rdData,
  output logic [NUM_DIV-1:0][2:0]   factorCode,
  output logic [NUM_DIV-1:0]        enBit
);

  localparam logic [7:0] FACTOR_OFS = 8'h43;
  localparam logic [7:0] ENABLE_OFS = 8'h46;

  int          instIdx;
  logic [7:0]  ofs;
  logic        unusedWrData;

  assign instIdx      = int'(addr >> 8);
  assign ofs          = addr[7:0];
  assign unusedWrData = ^wrData[6:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      factorCode <= '0;
      enBit      <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_DIV; i++) begin
        if (instIdx == i) begin
          if (ofs == FACTOR_OFS) factorCode[i] <= wrData[2:0];
          if (ofs == ENABLE_OFS) enBit[i]      <= wrData[7];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (instIdx == i) begin
        if (ofs == FACTOR_OFS)      rdData = {5'b0, factorCode[i]};
        else if (ofs == ENABLE_OFS) rdData = {enBit[i], 7'b0};
      end
    end
  end

endmodule

// File: rtl/divCtrl.sv
module divCtrl
  import divbank_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enReq,
  input  logic [2:0]  factorCode,
  output logic        busy,
  output logic        outOn,
  output logic [2:0]  heldCode,
  output gateStb_t    stb
);

  logic [CNT_W-1:0] settleCnt;
  logic [CNT_W-1:0] settleLen;
  logic             wantChange;

  assign wantChange = (enReq != outOn) && !busy;
  assign stb.start  = wantChange && enReq;
  assign stb.stop   = wantChange && !enReq;

  // Turn-on uses the stored code; turn-off uses the ratio in use
  assign settleLen = enReq ? CNT_W'(2 + 3 * ratioOf(factorCode))
                           : CNT_W'(3 * ratioOf(heldCode));

  always_ff @(posedge clk) begin
    if (rst) begin
      outOn     <= 1'b0;
      busy      <= 1'b0;
      settleCnt <= '0;
      heldCode  <= '0;
    end else if (wantChange) begin
      outOn     <= enReq;
      busy      <= 1'b1;
      settleCnt <= settleLen - 1'b1;
      if (enReq) heldCode <= factorCode;
    end else if (busy) begin
      if (settleCnt == '0) busy <= 1'b0;
      else                 settleCnt <= settleCnt - 1'b1;
    end
  end

  AST_BUSY_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    ((enReq != outOn) && !busy) |=> busy);  // R6

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (outOn && $past(outOn)) |-> $stable(heldCode));  // R9

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divbank_pkg::*;
#(
  parameter int HALF_W = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  gateStb_t    stb,
  input  logic [2:0]  code,
  output logic        divOut,
  output logic        running
);

  logic              ratio1;
  logic [HALF_W-1:0] halfM1;
  logic [HALF_W-1:0] cnt;
  logic              phase;
  logic              stopPend;
  logic              gateLo;
  logic              toggleNow;
  logic              nextPhase;
  logic              stopping;

  assign ratio1    = (code <= 3'd1);
  assign halfM1    = ratio1 ? '0 : HALF_W'(ratioOf(code) / 2 - 1);
  assign toggleNow = running && !ratio1 && (cnt == halfM1);
  assign nextPhase = toggleNow ? ~phase : phase;
  assign stopping  = stb.stop || stopPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      cnt      <= '0;
      phase    <= 1'b0;
      stopPend <= 1'b0;
    end else if (stb.start) begin
      running  <= 1'b1;
      cnt      <= '0;
      phase    <= 1'b0;
      stopPend <= 1'b0;
    end else if (running) begin
      if (ratio1) begin
        if (stopping) begin
          running  <= 1'b0;
          stopPend <= 1'b0;
        end
      end else if (stopping && !nextPhase) begin
        running  <= 1'b0;
        phase    <= 1'b0;
        cnt      <= '0;
        stopPend <= 1'b0;
      end else begin
        phase    <= nextPhase;
        cnt      <= toggleNow ? '0 : cnt + 1'b1;
        stopPend <= stopping;
      end
    end
  end

  // Gate for the pass-through path changes only while the reference is low
  always_ff @(negedge clk) begin
    if (rst) gateLo <= 1'b0;
    else     gateLo <= running && ratio1;
  end

  assign divOut = ratio1 ? (clk & gateLo) : phase;

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    stb.start |=> !phase);  // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!phase && !gateLo));  // R7

endmodule

// File: rtl/divClkBank.sv
module divClkBank
  import divbank_pkg::*;
#(
  parameter int NUM_DIV = 2,
  parameter int ADDR_W  = 8 + $clog2(NUM_DIV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic [NUM_DIV-1:0] divClkOut,
  output logic [NUM_DIV-1:0] divBusy
);

  localparam int CNT_W  = $clog2(2 + 3 * MAX_RATIO + 1);
  localparam int HALF_W = $clog2(MAX_RATIO);

  logic [NUM_DIV-1:0][2:0] factorCode;
  logic [NUM_DIV-1:0]      enBit;

  divRegFile #(.NUM_DIV(NUM_DIV), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (regWrEn),
    .addr       (regAddr),
    .wrData     (regWrData),
    .rdData     (regRdData),
    .factorCode (factorCode),
    .enBit      (enBit)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    gateStb_t   stb;
    logic       outOn;
    logic       running;
    logic [2:0] heldCode;

    divCtrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .enReq      (enBit[g]),
      .factorCode (factorCode[g]),
      .busy       (divBusy[g]),
      .outOn      (outOn),
      .heldCode   (heldCode),
      .stb        (stb)
    );

    divDatapath #(.HALF_W(HALF_W)) u_dp (
      .clk     (clk),
      .rst     (rst),
      .stb     (stb),
      .code    (heldCode),
      .divOut  (divClkOut[g]),
      .running (running)
    );

    AST_OFF_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
      ($fell(divBusy[g]) && !outOn) |-> !running);  // R7
  end

endmodule

// File: tb/sim_divClkBank.sv
module sim_divClkBank;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] divOut;
  logic [1:0] busy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  divClkBank #(.NUM_DIV(2)) u0 (
    .clk       (clk),
    .rst       (rst),
    .regWrEn   (wrEn),
    .regAddr   (addr),
    .regWrData (wrData),
    .regRdData (rdData),
    .divClkOut (divOut),
    .divBusy   (busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratioFor(input int code);
    return (code == 0) ? 1 : (1 << (code - 1));
  endfunction

  task automatic regWrite(input int inst, input int ofs, input logic [7:0] d);
    @(negedge clk);
    wrEn   = 1'b1;
    addr   = 9'(inst * 256 + ofs);
    wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic regRead(input int inst, input int ofs, output int v);
    @(negedge clk);
    addr = 9'(inst * 256 + ofs);
    #1;
    v = int'(rdData);
  endtask

  // Turn on divider inst (code already stored) and check settle and waveform
  task automatic enableRun(input int inst, input int code);
    int r = ratioFor(code);
    int s = 2 + 3 * r;
    int total = s + 2 * r + 6;
    int busyCnt = 0, firstRise = 0, hiRun = 0, loRun = 0, stage = 0, busyAt1 = 0;
    regWrite(inst, 'h46, 8'h80);
    for (int k = 1; k <= total; k++) begin
      @(posedge clk);
      #2;
      if (busy[inst]) busyCnt++;
      if (k == 1) busyAt1 = int'(busy[inst]);
      if (firstRise == 0) begin
        if (divOut[inst]) begin firstRise = k; hiRun = 1; end
      end else if (stage == 0) begin
        if (divOut[inst]) hiRun++;
        else begin stage = 1; loRun = 1; end
      end else if (stage == 1) begin
        if (!divOut[inst]) loRun++;
        else stage = 2;
      end
    end
    chk("R6 busy high on edge after write", busyAt1, 1);
    chk("R6 enable settle length", busyCnt, s);
    if (r == 1) begin
      chk("R8 first high phase ratio 1", firstRise, 2);
      @(posedge clk); #7;
      chk("R5 low phase follows reference", int'(divOut[inst]), 0);
      @(posedge clk); #2;
      chk("R5 high phase follows reference", int'(divOut[inst]), 1);
    end else begin
      chk("R8 first rising edge", firstRise, 1 + r / 2);
      chk("R4 high run", hiRun, r / 2);
      chk("R4 low run", loRun, r / 2);
    end
  endtask

  // Turn off divider inst running at ratio r and check settle and quiet output
  task automatic disableRun(input int inst, input int r);
    int busyCnt = 0, highAfter = 0;
    regWrite(inst, 'h46, 8'h00);
    for (int k = 1; k <= 3 * r + 6; k++) begin
      @(posedge clk);
      #2;
      if (busy[inst]) busyCnt++;
      if (k > 3 * r && divOut[inst]) highAfter++;
    end
    chk("R7 disable settle length", busyCnt, 3 * r);
    chk("R7 output low after settle", highAfter, 0);
  endtask

  task automatic measureRuns(input int inst, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    do begin @(posedge clk); #2; guard++; end while (divOut[inst] && guard < 300);
    do begin @(posedge clk); #2; guard++; end while (!divOut[inst] && guard < 300);
    while (divOut[inst] && guard < 300) begin hi++; @(posedge clk); #2; guard++; end
    while (!divOut[inst] && guard < 300) begin lo++; @(posedge clk); #2; guard++; end
  endtask

  initial begin
    int v, hi, lo;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    for (int i = 0; i < 2; i++) begin
      regRead(i, 'h43, v); chk("R1 factor after reset", v, 0);
      regRead(i, 'h46, v); chk("R1 enable after reset", v, 0);
    end
    chk("R1 outputs low", int'(divOut), 0);
    chk("R1 busy low", int'(busy), 0);

    // R2: unused bits and unmapped offsets
    regWrite(0, 'h46, 8'h7F);
    regRead(0, 'h46, v); chk("R2 enable ignores low bits", v, 0);
    chk("R2 no start from ignored bits", int'(busy[0]), 0);
    regWrite(0, 'h44, 8'hFF);
    regRead(0, 'h44, v); chk("R2 unmapped offset reads zero", v, 0);
    regRead(0, 'h43, v); chk("R2 factor untouched by unmapped write", v, 0);

    // R3: instance isolation
    regWrite(1, 'h43, 8'h05);
    regRead(0, 'h43, v); chk("R3 other divider factor unchanged", v, 0);
    regRead(1, 'h43, v); chk("R3 own factor written", v, 5);
    regWrite(1, 'h43, 8'h00);

    // Sweep every code on both dividers (R2, R4, R5, R6, R7, R8)
    for (int inst = 0; inst < 2; inst++) begin
      for (int code = 0; code < 8; code++) begin
        regWrite(inst, 'h43, 8'(8'hF8 | code));
        regRead(inst, 'h43, v); chk("R2 factor readback masked", v, code);
        enableRun(inst, code);
        regRead(inst, 'h46, v); chk("R2 enable readback", v, 128);
        chk("R3 other divider stays idle", int'(divOut[1 - inst] | busy[1 - inst]), 0);
        disableRun(inst, ratioFor(code));
      end
    end

    // R9: code change while running
    regWrite(0, 'h43, 8'd2);
    enableRun(0, 2);
    regWrite(0, 'h43, 8'd4);
    regRead(0, 'h43, v); chk("R9 new code reads back", v, 4);
    measureRuns(0, hi, lo);
    chk("R9 running high run unchanged", hi, 1);
    chk("R9 running low run unchanged", lo, 1);
    disableRun(0, 2);
    enableRun(0, 4);
    disableRun(0, 8);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule